// File: doc/BRIEF.md
# DDR Extended Mode Register Decoder

This block is the device-side decoder for the extended mode register of a DDR SDRAM. It watches the command bus each clock and recognises an extended register write, which is all four command strobes low with bank address bit 0 high. If the write is legal, it stores three settings: DLL enable, output drive strength and the identification reporting switch. When identification reporting is on, it drives a two-bit vendor and die-status code onto the low data bits.

The decoder also polices the command bus. It flags four kinds of fault, each as a one-cycle pulse:
- a write while banks are busy or clock enable was not already high;
- non-zero reserved address bits or the reserved drive code;
- a mode register command during the two-cycle write window;
- a READ during the settling time after the DLL is turned on, or before the register has ever been written.

An illegal write leaves the stored settings unchanged. A self refresh exit pulse turns the DLL on and restarts the READ lockout.

Top module: `ext_mode_reg`

## Requirements
- R1: A write is the command cs_n=0, ras_n=0, cas_n=0, we_n=0 with ba[0]=1. A legal write updates the outputs one clock after the edge that samples it. The same strobes with ba[0]=0 (a plain mode register command) change no stored setting.
- R2: A write is rejected and err_state pulses unless both hold:
  - banks_idle is high in the command cycle;
  - cke is high in the command cycle and in the cycle before it.
- R3: Address bit 0 selects the DLL. A value of 0 sets dll_on to 1, and a value of 1 clears it.
- R4: drive_code takes {addr[6], addr[1]}: 00 full, 01 weak, 11 matched. The code 10 is rejected and err_field pulses.
- R5: Address bit 11 sets id_en. While id_en is 1, dq_id equals {VENDOR_BIT, die_fail}, and VENDOR_BIT defaults to 0. Otherwise dq_id is 00.
- R6: A write is rejected and err_field pulses if any of these is non-zero:
  - address bits 2 to 5;
  - address bits 7 to 10;
  - ba[1].
- R7: Suppose a write is accepted at edge E. Any mode register command (either ba[0] value) sampled at edge E+1 pulses err_overlap and is not stored. A write at E+2 is accepted normally.
- R8: A READ is cs_n=0, ras_n=1, cas_n=0, we_n=1. Suppose a write at edge E0 turns the DLL from off to on. While the DLL stays on, a READ sampled at edge E0+k pulses err_read when k<200 and does not when k>=200. A write that keeps the DLL on does not restart this window.
- R9: A one-cycle sr_exit pulse at edge E sets dll_on. It restarts the R8 window from E, even if the DLL was already on.
- R10: After reset every output is 0 and cfg_valid is 0. Every READ pulses err_read until the first accepted write, which sets cfg_valid for good.
- R11: Each error flag is high for exactly the one cycle after the edge that sampled the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W | Address bus |
| banks_idle | input | 1 | All banks precharged |
| sr_exit | input | 1 | One-cycle self refresh exit pulse |
| die_fail | input | 1 | Static die test result, 1 = fail |
| dll_on | output | 1 | DLL enable setting |
| drive_code | output | 2 | Drive strength code |
| id_en | output | 1 | Identification reporting enabled |
| dq_id | output | 2 | Identification value for DQ[1:0] |
| cfg_valid | output | 1 | Register written since reset |
| err_state | output | 1 | Write outside idle or clock-enable conditions |
| err_field | output | 1 | Reserved bit or reserved drive code |
| err_overlap | output | 1 | Mode command inside the write window |
| err_read | output | 1 | READ during lockout or before first write |

## Verification
A stored setting that is corrupted, or updated by a rejected write, shows up on dll_on, drive_code, id_en or dq_id one clock after the offending command, and stays there until the next legal write. A write-window counter stuck at zero or left non-zero appears at the next mode command as a missing or false err_overlap. A lockout counter that is loaded wrongly, or not restarted, moves the first clean READ away from exactly 200 edges after the enabling event. It becomes visible only when a READ lands at 199 or 200 edges, so the bench places READs on both sides of that boundary.

// File: rtl/emr_pkg.sv
package emr_pkg;

  typedef enum logic [1:0] {
    CMD_OTHER = 2'd0,
    CMD_MRS   = 2'd1,
    CMD_EMRS  = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    DRV_FULL  = 2'b00,
    DRV_WEAK  = 2'b01,
    DRV_RSVD  = 2'b10,
    DRV_MATCH = 2'b11
  } drv_e;

  typedef struct packed {
    logic       dll_on;
    logic [1:0] drive;
    logic       id_en;
  } emr_cfg_t;

  localparam int BIT_DLL    = 0;
  localparam int BIT_DRV_LO = 1;
  localparam int BIT_DRV_HI = 6;
  localparam int BIT_ID     = 11;

  function automatic cmd_e classify(input logic cs_n, input logic ras_n,
                                    input logic cas_n, input logic we_n,
                                    input logic ba0);
    if (cs_n) return CMD_OTHER;
    if (!ras_n && !cas_n && !we_n) return ba0 ? CMD_EMRS : CMD_MRS;
    if (ras_n && !cas_n && we_n) return CMD_READ;
    return CMD_OTHER;
  endfunction

  function automatic logic drive_ok(input logic [1:0] code);
    return code != DRV_RSVD;
  endfunction

  function automatic logic kept_bit(input int idx);
    return (idx == BIT_DLL) || (idx == BIT_DRV_LO) ||
           (idx == BIT_DRV_HI) || (idx == BIT_ID);
  endfunction

  function automatic logic read_blocked(input logic is_read, input logic valid,
                                        input logic dll_on, input logic locked);
    return is_read && (!valid || (dll_on && locked));
  endfunction

endpackage

// File: rtl/emr_cmd_decode.sv
module emr_cmd_decode
  import emr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output cmd_e              cmd,
  output emr_cfg_t          cfg_new,
  output logic              field_bad
);

  logic [ADDR_W-1:0] rsvd_mask;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign rsvd_mask[i] = !kept_bit(i);
  end

  assign cmd = classify(cs_n, ras_n, cas_n, we_n, ba[0]);

  assign cfg_new.dll_on = !addr[BIT_DLL];
  assign cfg_new.drive  = {addr[BIT_DRV_HI], addr[BIT_DRV_LO]};
  assign cfg_new.id_en  = addr[BIT_ID];

  assign field_bad = (|(addr & rsvd_mask)) || ba[1] ||
                     !drive_ok({addr[BIT_DRV_HI], addr[BIT_DRV_LO]});

endmodule

// File: rtl/emr_cfg_reg.sv
module emr_cfg_reg
  import emr_pkg::*;
#(
  parameter int WR_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     emrs_cmd,
  input  logic     mrs_cmd,
  input  logic     state_bad,
  input  logic     field_bad,
  input  logic     sr_exit,
  input  emr_cfg_t cfg_new,
  output emr_cfg_t cfg_q,
  output logic     cfg_valid,
  output logic     wr_accept,
  output logic     dll_arm,
  output logic     err_state,
  output logic     err_field,
  output logic     err_overlap
);

  localparam int BW = $clog2(WR_CYC + 1);

  logic [BW-1:0] busy_q;
  logic          overlap_now;

  assign overlap_now = (emrs_cmd || mrs_cmd) && (busy_q != '0);
  assign wr_accept   = emrs_cmd && !state_bad && !field_bad && !overlap_now;
  assign dll_arm     = sr_exit || (wr_accept && cfg_new.dll_on && !cfg_q.dll_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= '0;
      cfg_q       <= '0;
      cfg_valid   <= 1'b0;
      err_state   <= 1'b0;
      err_field   <= 1'b0;
      err_overlap <= 1'b0;
    end else begin
      if (wr_accept)          busy_q <= BW'(WR_CYC - 1);
      else if (busy_q != '0)  busy_q <= busy_q - 1'b1;

      if (wr_accept) begin
        cfg_q     <= cfg_new;
        cfg_valid <= 1'b1;
      end else if (sr_exit) begin
        cfg_q.dll_on <= 1'b1;
      end

      err_state   <= emrs_cmd && state_bad;
      err_field   <= emrs_cmd && field_bad;
      err_overlap <= overlap_now;
    end
  end

endmodule

// File: rtl/emr_read_lock.sv
module emr_read_lock
  import emr_pkg::*;
#(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic is_read,
  input  logic dll_on,
  input  logic cfg_valid,
  output logic lock_active,
  output logic err_read
);

  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign lock_active = cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      err_read <= 1'b0;
    end else begin
      if (arm)              cnt_q <= CW'(LOCK_CYC - 1);
      else if (lock_active) cnt_q <= cnt_q - 1'b1;
      err_read <= read_blocked(is_read, cfg_valid, dll_on, lock_active);
    end
  end

endmodule

// File: rtl/ext_mode_reg.sv
module ext_mode_reg
  import emr_pkg::*;
#(
  parameter int   ADDR_W     = 12,
  parameter int   WR_CYC     = 2,
  parameter int   LOCK_CYC   = 200,
  parameter logic VENDOR_BIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              sr_exit,
  input  logic              die_fail,
  output logic              dll_on,
  output logic [1:0]        drive_code,
  output logic              id_en,
  output logic [1:0]        dq_id,
  output logic              cfg_valid,
  output logic              err_state,
  output logic              err_field,
  output logic              err_overlap,
  output logic              err_read
);

  cmd_e     cmd;
  emr_cfg_t cfg_new;
  emr_cfg_t cfg_q;
  logic     field_bad;
  logic     state_bad;
  logic     cke_q;
  logic     is_read;
  logic     is_emrs;
  logic     is_mrs;
  logic     wr_accept;
  logic     dll_arm;
  logic     lock_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  emr_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .cmd       (cmd),
    .cfg_new   (cfg_new),
    .field_bad (field_bad)
  );

  assign is_read   = cmd == CMD_READ;
  assign is_emrs   = cmd == CMD_EMRS;
  assign is_mrs    = cmd == CMD_MRS;
  assign state_bad = !banks_idle || !cke || !cke_q;

  emr_cfg_reg #(.WR_CYC(WR_CYC)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .emrs_cmd    (is_emrs),
    .mrs_cmd     (is_mrs),
    .state_bad   (state_bad),
    .field_bad   (field_bad),
    .sr_exit     (sr_exit),
    .cfg_new     (cfg_new),
    .cfg_q       (cfg_q),
    .cfg_valid   (cfg_valid),
    .wr_accept   (wr_accept),
    .dll_arm     (dll_arm),
    .err_state   (err_state),
    .err_field   (err_field),
    .err_overlap (err_overlap)
  );

  emr_read_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (dll_arm),
    .is_read     (is_read),
    .dll_on      (cfg_q.dll_on),
    .cfg_valid   (cfg_valid),
    .lock_active (lock_active),
    .err_read    (err_read)
  );

  assign dll_on     = cfg_q.dll_on;
  assign drive_code = cfg_q.drive;
  assign id_en      = cfg_q.id_en;
  assign dq_id      = cfg_q.id_en ? {VENDOR_BIT, die_fail} : 2'b00;

endmodule

// File: rtl/emr_checker.sv
module emr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_accept,
  input logic       is_read,
  input logic       sr_exit,
  input logic       lock_active,
  input logic       dll_on,
  input logic [1:0] drive_code,
  input logic       id_en,
  input logic [1:0] dq_id,
  input logic       cfg_valid,
  input logic       err_state,
  input logic       err_field,
  input logic       err_overlap,
  input logic       err_read
);

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_state || err_field || err_overlap) && !$past(sr_exit)
      |-> $stable({dll_on, drive_code, id_en})); // R2

  AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !(err_state || err_field || err_overlap)); // R1

  AST_NO_RSVD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> drive_code != 2'b10); // R4

  AST_DQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_en |-> dq_id == 2'b00); // R5

  AST_ONE_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept); // R7

  AST_LOCK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_on) |-> lock_active); // R8

  AST_SR_EXIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit && !wr_accept |=> dll_on && lock_active); // R9

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid); // R10

  AST_READ_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    is_read && !cfg_valid |=> err_read); // R10

endmodule

bind ext_mode_reg emr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_accept   (wr_accept),
  .is_read     (is_read),
  .sr_exit     (sr_exit),
  .lock_active (lock_active),
  .dll_on      (dll_on),
  .drive_code  (drive_code),
  .id_en       (id_en),
  .dq_id       (dq_id),
  .cfg_valid   (cfg_valid),
  .err_state   (err_state),
  .err_field   (err_field),
  .err_overlap (err_overlap),
  .err_read    (err_read)
);

// File: tb/ext_mode_reg_bench.sv
module ext_mode_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [11:0] addr = '0;
  logic        banks_idle = 1'b1;
  logic        sr_exit = 1'b0;
  logic        die_fail = 1'b1;
  logic        dll_on, id_en, cfg_valid;
  logic [1:0]  drive_code, dq_id;
  logic        err_state, err_field, err_overlap, err_read;

  always #4 clk = ~clk;

  ext_mode_reg u_ext_mode_reg (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .sr_exit(sr_exit), .die_fail(die_fail), .dll_on(dll_on),
    .drive_code(drive_code), .id_en(id_en), .dq_id(dq_id), .cfg_valid(cfg_valid),
    .err_state(err_state), .err_field(err_field), .err_overlap(err_overlap),
    .err_read(err_read)
  );

  typedef struct {
    int         due;
    logic [10:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // model state
  logic m_dll = 0, m_id = 0, m_valid = 0, m_ckeprev = 0;
  logic [1:0] m_drv = 0;
  int last_acc = -100;
  int lock_start = -1000;

  localparam logic [3:0] NOP = 4'b0111, MODE = 4'b0000, RDC = 4'b0101;

  // monitor: pops expected items once their edge has passed
  always @(negedge clk) begin
    exp_t e;
    logic [10:0] got;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      got = {dll_on, drive_code, id_en, dq_id, cfg_valid,
             err_state, err_field, err_overlap, err_read};
      n_chk++;
      if (got !== e.val) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", e.tag, got, e.val);
      end
    end
  end

  task automatic step(input logic [3:0] s, input logic [1:0] b, input logic [11:0] a,
                      input logic idle, input logic ck, input logic sre, input string tag);
    int E;
    bit emrs, mrs, rd, sbad, fbad, ovl, acc, rerr;
    exp_t it;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = s;
    ba = b; addr = a; banks_idle = idle; cke = ck; sr_exit = sre;
    E    = cyc + 1;
    emrs = (s == MODE) && b[0];
    mrs  = (s == MODE) && !b[0];
    rd   = (s == RDC);
    sbad = !idle || !ck || !m_ckeprev;
    fbad = ((a & 12'h7BC) != 0) || b[1] || ({a[6], a[1]} == 2'b10);
    ovl  = (emrs || mrs) && (E - last_acc < 2);
    acc  = emrs && !sbad && !fbad && !ovl;
    rerr = rd && (!m_valid || (m_dll && (E - lock_start < 200)));
    if (acc) begin
      if (!a[0] && !m_dll) lock_start = E;
      m_dll = !a[0]; m_drv = {a[6], a[1]}; m_id = a[11];
      m_valid = 1; last_acc = E;
    end else if (sre) m_dll = 1;
    if (sre) lock_start = E;
    m_ckeprev = ck;
    it.due = E;
    it.val = {m_dll, m_drv, m_id, (m_id ? {1'b0, die_fail} : 2'b00), m_valid,
              emrs && sbad, emrs && fbad, ovl, rerr};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic nop(input string tag);
    step(NOP, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input string tag);
    step(MODE, 2'b01, a, 1'b1, 1'b1, 1'b0, tag);
  endtask
  task automatic rd(input string tag);
    step(RDC, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0, tag);
  endtask
  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) nop("R11 idle");
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if ({dll_on, drive_code, id_en, dq_id, cfg_valid, err_state, err_field,
         err_overlap, err_read} !== 11'b0) begin
      n_bad++;
      $display("FAIL R10 reset: actual %b expected %b", {dll_on, drive_code, id_en,
               dq_id, cfg_valid, err_state, err_field, err_overlap, err_read}, 11'b0);
    end
    @(negedge clk); rst_n = 1'b1;
    nop("R10 after reset"); nop("R10 after reset");
    rd("R10 read before first write");
    wr(12'h004, "R6 reserved bit 2");
    step(MODE, 2'b11, 12'h000, 1'b1, 1'b1, 1'b0, "R6 ba1 set");
    wr(12'h040, "R4 reserved drive code");
    step(MODE, 2'b01, 12'h000, 1'b0, 1'b1, 1'b0, "R2 banks busy");
    step(MODE, 2'b01, 12'h000, 1'b1, 1'b0, 1'b0, "R2 cke low");
    step(MODE, 2'b01, 12'h000, 1'b1, 1'b1, 1'b0, "R2 cke just raised");
    step(MODE, 2'b00, 12'hFFF, 1'b1, 1'b1, 1'b0, "R1 plain mode cmd ignored");
    nop("R11 pulse end");
    wr(12'h000, "R1 R3 enable dll full drive");
    wr(12'h001, "R7 overlap write rejected");
    nop("R11 pulse end");
    rd("R8 read in lockout");
    wait_n(195);
    rd("R8 read at 199");
    rd("R8 read at 200");
    wr(12'h802, "R4 R5 weak drive id on");
    nop("R7 window"); rd("R8 no restart when already on");
    wr(12'h043, "R3 R4 matched drive dll off");
    nop("R7 window"); rd("R8 read with dll off");
    wr(12'h000, "R3 re-enable dll");
    step(MODE, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0, "R7 plain mode in window");
    wr(12'h800, "R7 write after window");
    nop("R7 window"); rd("R8 read in lockout again");
    wait_n(200);
    wr(12'h001, "R3 dll off");
    nop("R7 window");
    step(NOP, 2'b00, 12'h000, 1'b1, 1'b1, 1'b1, "R9 self refresh exit");
    nop("R9 idle"); rd("R9 read after exit");
    wait_n(200);
    rd("R9 clean read");
    step(NOP, 2'b00, 12'h000, 1'b1, 1'b1, 1'b1, "R9 exit while on");
    rd("R9 read after restart");
    nop("R11 pulse end");
    finish_run();
  end

endmodule